// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets an external host read and write a bank of 32-bit registers over a four-wire serial link: clock, active-low select, data in and data out. It runs on the chip's system clock. The serial clock, select and data-in pins pass through a short synchronizer, and the block finds the serial clock edges by comparing successive synchronized samples. Each transaction opens with an 8-bit command byte and an 8-bit register address. After those comes any number of 32-bit data words, which move in or out of the register bank.

Between words the engine holds the address, steps it up or steps it down, as the command byte selects. For reads, the register value is frozen at the start of each word, so the host never sees a half-updated value. A completion strobe lets the bank clear read-sensitive bits only after the whole word has left the device. For writes, the bank receives one write strobe per complete word. Addresses above the implemented range read as zero and never produce a strobe.

Top module: `spi_regacc`

## Requirements
- R1: The command byte 0x03, 0x07 or 0x0B selects a read and 0x02, 0x06 or 0x0A selects a write. Bit 0 set means read. Bits 3:2 choose the address step between words: 00 hold, 01 up, 10 down. With hold, every word of a burst accesses the same register.
- R2: After select falls, the command byte is taken first and the address byte second. Both arrive most significant bit first and are sampled on rising serial clock edges. Data-in bits are sampled the same way.
- R3: On a read, the data-out line is enabled and carries bit 31 of the word from the first falling serial clock edge after the last address bit's rising edge. Each later falling edge presents the next lower bit, and the next word follows at once.
- R4: When stepping up, the address after MAX_ADDR (default 63), or after any higher value, is 0.
- R5: When stepping down, the address after 0 is MAX_ADDR.
- R6: Each read word is captured whole before its first bit is sent. A register change during the word does not alter the bits the host receives.
- R7: Each fully shifted read word of an implemented address gives exactly one read-done pulse, with that word's address on the bank address port. A read word cut short by select rising gives no pulse.
- R8: Addresses above MAX_ADDR read as all zeros and produce neither a write strobe nor a read-done pulse.
- R9: When select is high, the data-out enable is low.
- R10: Any other command byte aborts the transaction. No strobe occurs and data-out stays disabled until select rises and falls again.
- R11: A write gives one write strobe per complete 32-bit word, carrying the word MSB-first as received. A trailing partial word is dropped.
- R12: After reset, the data-out enable and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from host (idle low) |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, valid when enabled |
| spi_miso_oe | output | 1 | Output enable for the data-out pad |
| reg_addr | output | 8 | Register bank address |
| reg_rdata | input | 32 | Register bank read data for reg_addr |
| reg_wdata | output | 32 | Register bank write data |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd_done | output | 1 | One-cycle pulse when a read word has fully shifted out |

## Verification
The bench goes after address wrap in both directions. A wrong wrap would return a word from the wrong register at the end of a burst. It also checks that a register cleared on read keeps its value through a cut-short read. A design that pulsed early would lose the data without delivering it. Further runs change a register in the middle of a word, send an unknown command byte, address unused space and stop a write part-way through. A design without a true snapshot would show mixed bits; a weak decoder or range check would show stray strobes or a driven output. Seeded random bursts cover all six command bytes at in-range and out-of-range addresses.

// File: rtl/spi_regacc_pkg.sv
package spi_regacc_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int CMD_W  = 8;
    localparam int CNT_W  = $clog2(DATA_W);

    typedef enum logic [1:0] {STEP_HOLD, STEP_UP, STEP_DOWN} step_e;

    typedef struct packed {
        logic  valid;
        logic  is_write;
        step_e step;
    } op_t;

    typedef enum logic [2:0] {PH_IDLE, PH_CMD, PH_ADDR, PH_DATA, PH_ABORT} phase_e;

    function automatic op_t decode_op(input logic [CMD_W-1:0] c);
        op_t o;
        case (c)
            8'h03:   o = '{valid: 1'b1, is_write: 1'b0, step: STEP_HOLD};
            8'h07:   o = '{valid: 1'b1, is_write: 1'b0, step: STEP_UP};
            8'h0B:   o = '{valid: 1'b1, is_write: 1'b0, step: STEP_DOWN};
            8'h02:   o = '{valid: 1'b1, is_write: 1'b1, step: STEP_HOLD};
            8'h06:   o = '{valid: 1'b1, is_write: 1'b1, step: STEP_UP};
            8'h0A:   o = '{valid: 1'b1, is_write: 1'b1, step: STEP_DOWN};
            default: o = '{valid: 1'b0, is_write: 1'b0, step: STEP_HOLD};
        endcase
        return o;
    endfunction
endpackage

// File: rtl/spi_regacc_sync.sv
module spi_regacc_sync #(
    parameter int            W       = 1,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_regacc_addr.sv
module spi_regacc_addr
    import spi_regacc_pkg::*;
#(
    parameter int MAX_ADDR = 63
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step_en,
    input  step_e             mode,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] TOP = ADDR_W'(MAX_ADDR);

    logic [ADDR_W-1:0] nxt;

    always_comb begin
        case (mode)
            STEP_UP:   nxt = (addr >= TOP) ? '0  : addr + 1'b1;
            STEP_DOWN: nxt = (addr == '0)  ? TOP : addr - 1'b1;
            default:   nxt = addr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)          addr <= '0;
        else if (load)    addr <= load_val;
        else if (step_en) addr <= nxt;
    end

    // R4
    up_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step_en && !load && mode == STEP_UP && addr == TOP) |=> (addr == '0));
    // R5
    down_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step_en && !load && mode == STEP_DOWN && addr == '0) |=> (addr == TOP));
    // R1
    hold_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (step_en && !load && mode == STEP_HOLD) |=> $stable(addr));
endmodule

// File: rtl/spi_regacc_rdshift.sv
module spi_regacc_rdshift
    import spi_regacc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] cap_data,
    input  logic              shift_en,
    input  logic              clear,
    output logic              miso,
    output logic              oe
);
    logic [DATA_W-1:0] snap;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap <= '0;
            miso <= 1'b0;
            oe   <= 1'b0;
        end else begin
            if (capture)       snap <= cap_data;
            else if (shift_en) snap <= {snap[DATA_W-2:0], 1'b0};
            if (clear) begin
                oe <= 1'b0;
            end else if (shift_en) begin
                miso <= snap[DATA_W-1];
                oe   <= 1'b1;
            end
        end
    end

    // R9
    oe_release_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> !oe);
    // R3
    oe_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !clear) |=> oe);
endmodule

// File: rtl/spi_regacc.sv
module spi_regacc
    import spi_regacc_pkg::*;
#(
    parameter int MAX_ADDR    = 63,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd_done
);
    localparam logic [ADDR_W-1:0] MAX_A     = ADDR_W'(MAX_ADDR);
    localparam logic [CNT_W-1:0]  LAST_BYTE = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0]  LAST_WORD = CNT_W'(DATA_W - 1);

    logic              cs_s, sck_s, mosi_s, sck_d;
    logic              sck_rise, sck_fall;
    phase_e            phase;
    logic [CNT_W-1:0]  cnt;
    logic [CMD_W-1:0]  sh;
    logic [CMD_W-1:0]  byte_in;
    op_t               op;
    logic [DATA_W-1:0] wsh;
    logic              adv, load;
    logic              a_load, in_range, shift_en;

    spi_regacc_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({spi_cs_n, spi_sck, spi_mosi}),
        .q   ({cs_s, sck_s, mosi_s})
    );

    assign sck_rise = sck_s & ~sck_d;
    assign sck_fall = ~sck_s & sck_d;
    assign byte_in  = {sh[CMD_W-2:0], mosi_s};
    assign in_range = (reg_addr <= MAX_A);
    assign a_load   = !cs_s && phase == PH_ADDR && sck_rise && cnt == LAST_BYTE;
    assign shift_en = !cs_s && phase == PH_DATA && !op.is_write && sck_fall;

    spi_regacc_addr #(.MAX_ADDR(MAX_ADDR)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .load     (a_load),
        .load_val (byte_in),
        .step_en  (adv),
        .mode     (op.step),
        .addr     (reg_addr)
    );

    spi_regacc_rdshift u_rd (
        .clk      (clk),
        .rst      (rst),
        .capture  (load),
        .cap_data (in_range ? reg_rdata : '0),
        .shift_en (shift_en),
        .clear    (cs_s),
        .miso     (spi_miso),
        .oe       (spi_miso_oe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d       <= 1'b0;
            phase       <= PH_IDLE;
            cnt         <= '0;
            sh          <= '0;
            op          <= '{valid: 1'b0, is_write: 1'b0, step: STEP_HOLD};
            wsh         <= '0;
            reg_wdata   <= '0;
            reg_wr      <= 1'b0;
            reg_rd_done <= 1'b0;
            adv         <= 1'b0;
            load        <= 1'b0;
        end else begin
            sck_d       <= sck_s;
            reg_wr      <= 1'b0;
            reg_rd_done <= 1'b0;
            adv         <= 1'b0;
            load        <= adv && !op.is_write;
            if (cs_s) begin
                phase <= PH_IDLE;
            end else begin
                case (phase)
                    PH_IDLE: begin
                        phase <= PH_CMD;
                        cnt   <= '0;
                    end
                    PH_CMD: if (sck_rise) begin
                        sh  <= byte_in;
                        cnt <= cnt + 1'b1;
                        if (cnt == LAST_BYTE) begin
                            op    <= decode_op(byte_in);
                            phase <= decode_op(byte_in).valid ? PH_ADDR : PH_ABORT;
                            cnt   <= '0;
                        end
                    end
                    PH_ADDR: if (sck_rise) begin
                        sh  <= byte_in;
                        cnt <= cnt + 1'b1;
                        if (cnt == LAST_BYTE) begin
                            phase <= PH_DATA;
                            cnt   <= '0;
                            load  <= !op.is_write;
                        end
                    end
                    PH_DATA: if (sck_rise) begin
                        cnt <= cnt + 1'b1;
                        wsh <= {wsh[DATA_W-2:0], mosi_s};
                        if (cnt == LAST_WORD) begin
                            adv <= 1'b1;
                            if (op.is_write) begin
                                reg_wdata <= {wsh[DATA_W-2:0], mosi_s};
                                reg_wr    <= in_range;
                            end else begin
                                reg_rd_done <= in_range;
                            end
                        end
                    end
                    default: phase <= PH_ABORT;
                endcase
            end
        end
    end

    // R7 R11
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_rd_done));
    // R8
    strobe_range_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr || reg_rd_done) |-> (reg_addr <= MAX_A));
    // R10
    abort_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ABORT) |-> (!reg_wr && !reg_rd_done && !spi_miso_oe));
endmodule

// File: tb/spi_regacc_test.sv
module spi_regacc_test;
    localparam int MAX_ADDR = 63;
    localparam int HP       = 8;
    localparam int COR      = 5;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst = 1'b1;
    logic        sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic        miso, miso_oe, reg_wr, reg_rd_done;
    logic [7:0]  reg_addr;
    logic [31:0] reg_rdata, reg_wdata;

    logic [31:0] regs [0:MAX_ADDR];
    logic [31:0] mdl  [0:MAX_ADDR];
    logic [7:0]  rd_log [0:63];
    int          wr_n = 0, rd_n = 0;
    logic        init_req = 1'b0, poke_req = 1'b0;
    logic [5:0]  poke_a = '0;
    logic [31:0] poke_v = '0;
    int          poke_bit = -1;

    logic [31:0] tx_w [0:7];
    logic [31:0] rx_w [0:7];
    logic [31:0] exp_rx [0:7];
    int          exp_rd, exp_wr;
    logic        oe_all, oe_any;
    int          checks = 0, errors = 0;

    spi_regacc #(.MAX_ADDR(MAX_ADDR)) uut (
        .clk (clk), .rst (rst), .spi_sck (sck), .spi_cs_n (cs_n), .spi_mosi (mosi),
        .spi_miso (miso), .spi_miso_oe (miso_oe), .reg_addr (reg_addr),
        .reg_rdata (reg_rdata), .reg_wdata (reg_wdata), .reg_wr (reg_wr),
        .reg_rd_done (reg_rd_done)
    );

    assign reg_rdata = (reg_addr <= 8'(MAX_ADDR)) ? regs[reg_addr[5:0]]
                                                  : {16'hDEAD, 8'h00, reg_addr};

    function automatic logic [31:0] init_val(input int i);
        return {8'hA0, 8'(i), 16'(i * 37 + 1)};
    endfunction

    always @(posedge clk) begin
        if (init_req) for (int i = 0; i <= MAX_ADDR; i++) regs[i] <= init_val(i);
        if (poke_req) regs[poke_a] <= poke_v;
        if (reg_wr) begin
            if (reg_addr <= 8'(MAX_ADDR)) regs[reg_addr[5:0]] <= reg_wdata;
            wr_n <= wr_n + 1;
        end
        if (reg_rd_done) begin
            rd_log[rd_n[5:0]] <= reg_addr;
            rd_n <= rd_n + 1;
            if (reg_addr == 8'(COR)) regs[COR] <= '0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] nxt_a(input logic [7:0] a, input logic [1:0] m);
        if (m == 2'b01) return (a >= 8'(MAX_ADDR)) ? 8'd0 : a + 8'd1;
        if (m == 2'b10) return (a == 8'd0) ? 8'(MAX_ADDR) : a - 8'd1;
        return a;
    endfunction

    task automatic model(input logic [7:0] op, input logic [7:0] a, input int n);
        logic [7:0] p = a;
        exp_rd = 0; exp_wr = 0;
        for (int w = 0; w < n; w++) begin
            if (op[0]) begin
                exp_rx[w] = (p <= 8'(MAX_ADDR)) ? mdl[p[5:0]] : 32'h0;
                if (p <= 8'(MAX_ADDR)) exp_rd++;
                if (p == 8'(COR)) mdl[COR] = '0;
            end else if (p <= 8'(MAX_ADDR)) begin
                mdl[p[5:0]] = tx_w[w];
                exp_wr++;
            end
            p = nxt_a(p, op[3:2]);
        end
    endtask

    task automatic bit_x(input logic b, output logic got, output logic oe);
        @(negedge clk) mosi = b;
        repeat (HP) @(negedge clk);
        got = miso; oe = miso_oe;
        sck = 1'b1;
        repeat (HP) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] op, input logic [7:0] a, input int n, input int extra);
        logic g, o;
        oe_all = 1'b1; oe_any = 1'b0;
        @(negedge clk) cs_n = 1'b0;
        repeat (HP) @(negedge clk);
        for (int i = 7; i >= 0; i--) begin bit_x(op[i], g, o); oe_any |= o; end
        for (int i = 7; i >= 0; i--) begin bit_x(a[i], g, o); oe_any |= o; end
        for (int w = 0; w < n; w++) begin
            for (int i = 31; i >= 0; i--) begin
                if (w == 0 && i == 31 - poke_bit) begin
                    @(negedge clk) poke_req = 1'b1;
                    @(negedge clk) poke_req = 1'b0;
                end
                bit_x(tx_w[w][i], g, o);
                rx_w[w][i] = g; oe_all &= o; oe_any |= o;
            end
        end
        for (int i = 0; i < extra; i++) begin bit_x(1'b1, g, o); oe_any |= o; end
        repeat (HP) @(negedge clk);
        cs_n = 1'b1;
        repeat (4 * HP) @(negedge clk);
    endtask

    task automatic txn(input string req, input logic [7:0] op, input logic [7:0] a, input int n);
        int r0 = rd_n, w0 = wr_n;
        model(op, a, n);
        xfer(op, a, n, 0);
        if (op[0]) begin
            for (int w = 0; w < n; w++) chk(req, rx_w[w], exp_rx[w]);
            chk({req, " R3 oe"}, 32'(oe_all), 32'd1);
            chk({req, " R7 rd strobes"}, 32'(rd_n - r0), 32'(exp_rd));
        end else begin
            chk({req, " R11 wr strobes"}, 32'(wr_n - w0), 32'(exp_wr));
            for (int i = 0; i <= MAX_ADDR; i++)
                if (regs[i] !== mdl[i]) chk({req, " R11 bank"}, regs[i], mdl[i]);
        end
        chk("R9 oe after deselect", 32'(miso_oe), 32'd0);
    endtask

    initial begin
        int unsigned seed_dummy;
        int r0, w0;
        logic [7:0] ops [0:5];
        ops = '{8'h03, 8'h07, 8'h0B, 8'h02, 8'h06, 8'h0A};
        seed_dummy = $urandom(1234);
        for (int i = 0; i <= MAX_ADDR; i++) mdl[i] = init_val(i);
        init_req = 1'b1;
        repeat (4) @(negedge clk);
        init_req = 1'b0; rst = 1'b0;
        @(negedge clk);
        // R12
        chk("R12 oe", 32'(miso_oe), 0);
        chk("R12 strobes", 32'({reg_wr, reg_rd_done}), 0);

        // R1 R7 hold read of clear-on-read register: value then zero
        txn("R1 R7 hold burst", 8'h03, 8'(COR), 2);
        chk("R7 rd addr", 32'(rd_log[(rd_n - 1) & 63]), COR);

        // R7 partial read must not clear
        tx_w[0] = 32'hCAFE_1234; txn("R2 write", 8'h02, 8'(COR), 1);
        r0 = rd_n;
        xfer(8'h03, 8'(COR), 0, 20);
        chk("R7 partial no pulse", 32'(rd_n - r0), 0);
        txn("R7 full read after partial", 8'h03, 8'(COR), 1);

        // R4 increment wrap
        r0 = rd_n;
        txn("R4 up wrap", 8'h07, 8'd62, 3);
        chk("R4 log0", 32'(rd_log[r0 & 63]), 62);
        chk("R4 log1", 32'(rd_log[(r0 + 1) & 63]), 63);
        chk("R4 log2", 32'(rd_log[(r0 + 2) & 63]), 0);

        // R5 decrement wrap
        r0 = rd_n;
        txn("R5 down wrap", 8'h0B, 8'd1, 3);
        chk("R5 log2", 32'(rd_log[(r0 + 2) & 63]), MAX_ADDR);

        // R8 unused addresses
        txn("R8 unused read", 8'h03, 8'd100, 1);
        tx_w[0] = 32'h1111_2222; txn("R8 unused write", 8'h02, 8'd200, 1);

        // R10 bad command
        r0 = rd_n; w0 = wr_n;
        xfer(8'h05, 8'd3, 1, 0);
        chk("R10 oe stays off", 32'(oe_any), 0);
        chk("R10 no strobes", 32'((rd_n - r0) + (wr_n - w0)), 0);
        txn("R10 recovery read", 8'h03, 8'd3, 1);

        // R6 snapshot: change mid-word
        poke_a = 6'd10; poke_v = 32'h0BAD_F00D; poke_bit = 10;
        txn("R6 snapshot", 8'h03, 8'd10, 1);
        poke_bit = -1; mdl[10] = 32'h0BAD_F00D;
        txn("R6 new value visible", 8'h03, 8'd10, 1);

        // R11 partial final write dropped, burst with wrap
        w0 = wr_n;
        tx_w[0] = 32'h8765_4321;
        model(8'h02, 8'd20, 1);
        xfer(8'h02, 8'd20, 1, 12);
        chk("R11 partial strobes", 32'(wr_n - w0), 1);
        chk("R11 partial data", regs[20], 32'h8765_4321);
        tx_w[0] = 32'hFFFF_0001; tx_w[1] = 32'h0000_FFFE;
        txn("R11 R4 write up wrap", 8'h06, 8'd63, 2);

        // random mix
        for (int t = 0; t < 20; t++) begin
            logic [7:0] op, a;
            int n;
            op = ops[$urandom_range(0, 5)];
            a  = 8'($urandom_range(0, 70));
            n  = $urandom_range(1, 3);
            for (int w = 0; w < n; w++) tx_w[w] = $urandom;
            txn("R1 R2 random", op, a, n);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule